// File: doc/BRIEF.md
# Subband Ping-Pong Buffer Switch

This block sits between two lifting stages of a wavelet packet pipeline. It holds two frame-sized memory banks. While the upstream stage fills one bank with the subband coefficients of the current frame, the other bank replays the previous frame. The two banks trade roles only on a frame boundary. A frame is therefore delayed by exactly one frame period, and the write side and the read side work in parallel.

A frame of length L is held as `NSUB = 2**LEVEL` equal-length subbands. The frame is written in arrival order, so subband j covers addresses j*L/NSUB up to (j+1)*L/NSUB-1. With `LEVEL = 1` this puts the low-pass half first and the high-pass half second.

A per-frame split mask decides where each stored subband goes on replay. A subband whose bit is set is decomposed further, so it streams to the next-stage port. A subband whose bit is clear is a leaf of the tree, so it leaves on a separate result port tagged with its node level and index. This lets an arbitrary wavelet packet tree be built out of a chain of identical stages.

Top module: `sbpp_switch`

## Requirements
- R1: While reset is applied, and until the first input sample: `in_ready` is 1, and `nxt_valid`, `res_valid` and `frame_done` are 0. `rst_n` is asynchronous and active low; its release takes effect through a two-flop synchronizer.
- R2: The frame length is L = 128 << `cfg_len_sel` (0→128, 1→256, 2→512, 3→1024). Once L samples of a frame have been accepted, `in_ready` is 0 from the next cycle until the banks swap.
- R3: Every accepted sample is replayed exactly once, in arrival order, with its value unchanged. Frame n is replayed only after frame n has been fully written.
- R4: In replay, the sample at frame position p belongs to subband j = p / (L/NSUB), with bit j of the mask being bit j of `cfg_split_mask`. If bit j is 1, the sample is offered on the next-stage port. If bit j is 0, it is offered on the result port with `res_level` = LEVEL and `res_index` = j.
- R5: The length select and the split mask are sampled in the cycle that accepts the first sample of a frame. Changes made later in that frame affect only the following frame.
- R6: `nxt_valid` and `res_valid` are never 1 in the same cycle.
- R7: An offered sample that is not accepted stays offered on the same port, with its data and tag unchanged.
- R8: `frame_done` is a one-cycle pulse in the cycle after the last sample of a replayed frame is accepted.
- R9: Input samples of the next frame are accepted while the previous frame is still being replayed.
- R10: The banks swap in the first cycle in which the write frame is complete and no frame is being replayed. The first sample of the swapped frame is offered in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream sample valid |
| in_ready | output | 1 | Write bank can take a sample |
| in_data | input | DATA_W | Upstream coefficient |
| cfg_len_sel | input | SEL_W (2) | Frame length select, sampled at frame start |
| cfg_split_mask | input | NSUB (4) | Per-subband split bits, sampled at frame start |
| nxt_valid | output | 1 | Sample offered to the next stage |
| nxt_ready | input | 1 | Next stage accepts |
| nxt_data | output | DATA_W | Sample to the next stage |
| res_valid | output | 1 | Leaf coefficient offered |
| res_ready | input | 1 | Result sink accepts |
| res_data | output | DATA_W | Leaf coefficient |
| res_level | output | 4 | Tree level of the leaf node |
| res_index | output | LEVEL (2) | Index of the leaf node within its level |
| frame_done | output | 1 | Replay of a frame finished |

## Verification
The bench targets the moments when the banks change roles. It stalls both output ports long enough for a full write frame to back up behind a frame that has not finished replaying. A design that swapped early would corrupt the frame being replayed, and one that never released `in_ready` would hang.

Mid-frame changes to the mask and length select are driven to catch a design that samples configuration continuously instead of once per frame. Such a design would misroute or cut short a subband.

Every subband boundary is crossed with masks that flip between adjacent subbands, including all-split and all-leaf frames. An off-by-one in the subband index would then send samples to the wrong port or with the wrong tag. Lengths from 128 to 1024 are mixed frame by frame, which exposes a design that keeps the previous frame's length for its last-address compare.

// File: rtl/sbpp_pkg.sv
package sbpp_pkg;

  // Width of the tree level tag (up to 8 decomposition levels).
  localparam int LVL_W = 4;

  typedef enum logic {
    ROUTE_RES = 1'b0,
    ROUTE_NXT = 1'b1
  } route_e;

  // log2 of the frame length for a select code, clamped to the bank depth.
  function automatic int log2_len(input int sel, input int lmin, input int lmax);
    int v;
    v = lmin + sel;
    if (v > lmax) v = lmax;
    return v;
  endfunction

endpackage

// File: rtl/sbpp_bank.sv
module sbpp_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/sbpp_fill.sv
module sbpp_fill
  import sbpp_pkg::*;
#(
  parameter int AW      = 10,
  parameter int SEL_W   = 2,
  parameter int NSUB    = 4,
  parameter int LOG_MIN = 7,
  parameter int LOG_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SEL_W-1:0] cfg_len_sel,
  input  logic [NSUB-1:0]  cfg_split_mask,
  input  logic             release_i,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             full_o,
  output logic [SEL_W-1:0] len_o,
  output logic [NSUB-1:0]  mask_o
);

  logic [AW-1:0]    cnt_q, cnt_d;
  logic             full_q, full_d;
  logic [SEL_W-1:0] len_q, eff_sel;
  logic [NSUB-1:0]  mask_q;
  logic [AW-1:0]    last_addr;
  logic             fire, cnt_en, full_en, cfg_en;

  always_comb begin
    fire      = in_valid && !full_q;
    eff_sel   = (cnt_q == '0) ? cfg_len_sel : len_q;
    last_addr = AW'((32'd1 << log2_len(int'(eff_sel), LOG_MIN, LOG_MAX)) - 32'd1);
    cnt_en    = fire;
    cfg_en    = fire && (cnt_q == '0);
    full_en   = fire || release_i;
    cnt_d     = cnt_q;
    full_d    = full_q;
    if (fire) begin
      if (cnt_q == last_addr) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_q + AW'(1);
      end
    end
    if (release_i) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      len_q  <= '0;
      mask_q <= '0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (full_en) full_q <= full_d;
      if (cfg_en) begin
        len_q  <= cfg_len_sel;
        mask_q <= cfg_split_mask;
      end
    end
  end

  assign in_ready = !full_q;
  assign wr_en    = fire;
  assign wr_addr  = cnt_q;
  assign full_o   = full_q;
  assign len_o    = len_q;
  assign mask_o   = mask_q;

  assert_full_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cnt_q == last_addr) |=> !in_ready);

  assert_cfg_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 || full_q) |=> ($stable(len_q) && $stable(mask_q)));

endmodule

// File: rtl/sbpp_drain.sv
module sbpp_drain
  import sbpp_pkg::*;
#(
  parameter int AW      = 10,
  parameter int SEL_W   = 2,
  parameter int LEVEL   = 2,
  parameter int LOG_MIN = 7,
  parameter int LOG_MAX = 10,
  localparam int NSUB   = 1 << LEVEL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEL_W-1:0] load_len,
  input  logic [NSUB-1:0]  load_mask,
  input  logic             nxt_ready,
  input  logic             res_ready,
  output logic             busy_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic             nxt_valid,
  output logic             res_valid,
  output logic [LEVEL-1:0] res_index,
  output logic             frame_done
);

  logic [AW-1:0]    ptr_q, ptr_d, last_addr;
  logic             busy_q, busy_d, done_q, done_d;
  logic [SEL_W-1:0] len_q;
  logic [NSUB-1:0]  mask_q;
  logic [LEVEL-1:0] sub;
  route_e           route;
  logic             fire, ptr_en;
  int               lg;

  always_comb begin
    lg        = log2_len(int'(len_q), LOG_MIN, LOG_MAX);
    last_addr = AW'((32'd1 << lg) - 32'd1);
    sub       = LEVEL'(ptr_q >> (lg - LEVEL));
    route     = route_e'(mask_q[sub]);
    nxt_valid = busy_q && (route == ROUTE_NXT);
    res_valid = busy_q && (route == ROUTE_RES);
    fire      = (nxt_valid && nxt_ready) || (res_valid && res_ready);
    ptr_en    = load_i || fire;
    ptr_d     = ptr_q;
    busy_d    = busy_q;
    done_d    = 1'b0;
    if (load_i) begin
      ptr_d  = '0;
      busy_d = 1'b1;
    end else if (fire) begin
      if (ptr_q == last_addr) begin
        ptr_d  = '0;
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        ptr_d = ptr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      len_q  <= '0;
      mask_q <= '0;
    end else begin
      done_q <= done_d;
      if (ptr_en) begin
        ptr_q  <= ptr_d;
        busy_q <= busy_d;
      end
      if (load_i) begin
        len_q  <= load_len;
        mask_q <= load_mask;
      end
    end
  end

  assign busy_o     = busy_q;
  assign rd_addr_o  = ptr_d;
  assign res_index  = sub;
  assign frame_done = done_q;

  assert_one_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(nxt_valid && res_valid));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(busy_q) && !busy_q));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

// File: rtl/sbpp_switch.sv
module sbpp_switch
  import sbpp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MIN_LEN = 128,
  parameter int MAX_LEN = 1024,
  parameter int LEVEL   = 2,
  localparam int LOG_MIN = $clog2(MIN_LEN),
  localparam int LOG_MAX = $clog2(MAX_LEN),
  localparam int AW      = LOG_MAX,
  localparam int SEL_W   = (LOG_MAX > LOG_MIN) ? $clog2(LOG_MAX - LOG_MIN + 1) : 1,
  localparam int NSUB    = 1 << LEVEL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SEL_W-1:0]  cfg_len_sel,
  input  logic [NSUB-1:0]   cfg_split_mask,
  output logic              nxt_valid,
  input  logic              nxt_ready,
  output logic [DATA_W-1:0] nxt_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic [LVL_W-1:0]  res_level,
  output logic [LEVEL-1:0]  res_index,
  output logic              frame_done
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sr;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= '0;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_i_n = rst_sr[1];

  logic             fill_wr_en, fill_full, drain_busy, swap;
  logic [AW-1:0]    fill_addr, drain_addr;
  logic [SEL_W-1:0] fill_len;
  logic [NSUB-1:0]  fill_mask;
  logic             wsel_q, wsel_d;
  logic [DATA_W-1:0] bank_q [2];
  logic [DATA_W-1:0] out_data;

  always_comb begin
    swap   = fill_full && !drain_busy;
    wsel_d = wsel_q ^ swap;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)  wsel_q <= 1'b0;
    else if (swap) wsel_q <= wsel_d;
  end

  sbpp_fill #(
    .AW(AW), .SEL_W(SEL_W), .NSUB(NSUB), .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX)
  ) fill_i (
    .clk(clk), .rst_n(rst_i_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .cfg_len_sel(cfg_len_sel), .cfg_split_mask(cfg_split_mask),
    .release_i(swap),
    .wr_en(fill_wr_en), .wr_addr(fill_addr),
    .full_o(fill_full), .len_o(fill_len), .mask_o(fill_mask)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    sbpp_bank #(.DATA_W(DATA_W), .DEPTH(MAX_LEN)) bank_i (
      .clk(clk),
      .wr_en(fill_wr_en && (wsel_q == 1'(b))),
      .wr_addr(fill_addr),
      .wr_data(in_data),
      .rd_addr(drain_addr),
      .rd_data(bank_q[b])
    );
  end

  sbpp_drain #(
    .AW(AW), .SEL_W(SEL_W), .LEVEL(LEVEL), .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX)
  ) drain_i (
    .clk(clk), .rst_n(rst_i_n),
    .load_i(swap), .load_len(fill_len), .load_mask(fill_mask),
    .nxt_ready(nxt_ready), .res_ready(res_ready),
    .busy_o(drain_busy), .rd_addr_o(drain_addr),
    .nxt_valid(nxt_valid), .res_valid(res_valid),
    .res_index(res_index), .frame_done(frame_done)
  );

  assign out_data  = bank_q[~wsel_q];
  assign nxt_data  = out_data;
  assign res_data  = out_data;
  assign res_level = LVL_W'(LEVEL);

  assert_hold_nxt_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (nxt_valid && !nxt_ready) |=> (nxt_valid && $stable(nxt_data)));

  assert_hold_res_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_index)));

  assert_swap_gate_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(drain_busy) |-> $past(fill_full));

  assert_bank_toggle_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(drain_busy) |-> (wsel_q != $past(wsel_q)));

endmodule

// File: tb/sbpp_switch_tb_top.sv
module sbpp_switch_tb_top;

  localparam int NSUB = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [15:0] in_data;
  logic [1:0]  cfg_len_sel;
  logic [3:0]  cfg_split_mask;
  logic        nxt_valid, nxt_ready, res_valid, res_ready, frame_done;
  logic [15:0] nxt_data, res_data;
  logic [3:0]  res_level;
  logic [1:0]  res_index;

  always #5 clk = ~clk;

  sbpp_switch dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_len_sel(cfg_len_sel), .cfg_split_mask(cfg_split_mask),
    .nxt_valid(nxt_valid), .nxt_ready(nxt_ready), .nxt_data(nxt_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_level(res_level), .res_index(res_index), .frame_done(frame_done)
  );

  int n_checks = 0;
  int n_err    = 0;
  bit chk_en   = 0;
  int rdy_pct  = 100;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  // Behavioural reference model, advanced on every rising edge.
  int wq[$];
  int rq[$];
  int rroute[$];
  int ridx[$];
  int m_wcnt, m_wlen, acc_total, out_total, done_total, overlap;
  bit m_full, m_busy, m_done;
  logic [3:0] m_wmask;

  always @(posedge clk) begin
    if (!rst_n) begin
      wq.delete(); rq.delete(); rroute.delete(); ridx.delete();
      m_wcnt = 0; m_wlen = 128; m_full = 0; m_busy = 0; m_done = 0;
      m_wmask = '0;
    end else begin
      bit in_fire, o_fire, swap;
      in_fire = in_valid && !m_full;
      o_fire  = m_busy && (rroute[0] != 0 ? nxt_ready : res_ready);
      swap    = m_full && !m_busy;
      m_done  = 0;
      if (in_fire) begin
        if (m_busy) overlap++;
        if (m_wcnt == 0) begin
          m_wlen  = 128 << cfg_len_sel;
          m_wmask = cfg_split_mask;
        end
        wq.push_back(int'(in_data));
        acc_total++;
        m_wcnt++;
        if (m_wcnt == m_wlen) begin
          m_full = 1;
          m_wcnt = 0;
        end
      end
      if (o_fire) begin
        void'(rq.pop_front()); void'(rroute.pop_front()); void'(ridx.pop_front());
        out_total++;
        if (rq.size() == 0) begin
          m_busy = 0;
          m_done = 1;
          done_total++;
        end
      end
      if (swap) begin
        int seg;
        seg = m_wlen / NSUB;
        for (int p = 0; p < wq.size(); p++) begin
          rq.push_back(wq[p]);
          ridx.push_back(p / seg);
          rroute.push_back(int'(m_wmask[p / seg]));
        end
        wq.delete();
        m_busy = 1;
        m_full = 0;
      end
    end
  end

  // Compare DUT against the model away from the active edge.
  always @(negedge clk) begin
    if (chk_en) begin
      bit en, er;
      en = m_busy && rroute[0] != 0;
      er = m_busy && rroute[0] == 0;
      chk(in_ready == !m_full, "R2", "in_ready", int'(in_ready), int'(!m_full));
      chk(nxt_valid == en, "R4", "nxt_valid", int'(nxt_valid), int'(en));
      chk(res_valid == er, "R4", "res_valid", int'(res_valid), int'(er));
      chk(frame_done == m_done, "R8", "frame_done", int'(frame_done), int'(m_done));
      if (en) chk(int'(nxt_data) == rq[0], "R3", "nxt_data", int'(nxt_data), rq[0]);
      if (er) begin
        chk(int'(res_data) == rq[0], "R3", "res_data", int'(res_data), rq[0]);
        chk(int'(res_index) == ridx[0], "R4", "res_index", int'(res_index), ridx[0]);
        chk(res_level == 4'd2, "R4", "res_level", int'(res_level), 2);
      end
    end
  end

  // Random backpressure on both output ports.
  always @(negedge clk) begin
    nxt_ready <= ($urandom_range(99) < rdy_pct);
    res_ready <= ($urandom_range(99) < rdy_pct);
  end

  // Watchdog.
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  // Sends one frame; called and returns at a falling edge.
  task automatic send_frame(int sel, logic [3:0] mask, int vpct, bit twiddle);
    int n, base;
    n = 128 << sel;
    base = acc_total;
    cfg_len_sel    = 2'(sel);
    cfg_split_mask = mask;
    while (acc_total - base < n) begin
      in_data  = 16'(acc_total);
      in_valid = ($urandom_range(99) < vpct);
      // R5: disturb configuration after the first sample has been taken
      if (twiddle && (acc_total - base) >= 1) begin
        cfg_len_sel    = 2'($urandom_range(3));
        cfg_split_mask = 4'($urandom_range(15));
      end
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_data = '0;
    cfg_len_sel = '0; cfg_split_mask = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    chk(nxt_valid == 1'b0, "R1", "nxt_valid", int'(nxt_valid), 0);
    chk(res_valid == 1'b0, "R1", "res_valid", int'(res_valid), 0);
    chk(frame_done == 1'b0, "R1", "frame_done", int'(frame_done), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1 && !nxt_valid && !res_valid, "R1", "idle after release",
        int'({in_ready, nxt_valid, res_valid}), 4);
    chk_en = 1;

    rdy_pct = 100;
    send_frame(0, 4'b1111, 100, 0);   // all subbands split further
    send_frame(0, 4'b0000, 100, 0);   // all leaves
    // R10: stall both outputs so a complete write frame backs up
    rdy_pct = 0;
    fork
      begin repeat (2500) @(negedge clk); rdy_pct = 60; end
    join_none
    send_frame(1, 4'b0101, 70, 0);
    send_frame(0, 4'b1010, 80, 1);    // R5: mid-frame config changes
    send_frame(2, 4'b0110, 50, 0);
    rdy_pct = 90;
    send_frame(3, 4'b1001, 90, 0);
    rdy_pct = 40;
    send_frame(0, 4'b0011, 100, 1);
    send_frame(1, 4'b1100, 100, 0);

    while (m_busy || m_full || wq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(out_total == acc_total, "R3", "samples out vs in", out_total, acc_total);
    chk(done_total == 8, "R8", "frame_done pulses", done_total, 8);
    chk(overlap > 0, "R9", "writes during replay", overlap, 1);
    chk(nxt_valid == 0 && res_valid == 0, "R6", "idle at end",
        int'({nxt_valid, res_valid}), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule